// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Host Controller

This block is the host-side master for a serial 8-bit converter that takes its channel selection and returns its result over one short synchronous frame. A local requester supplies a channel number, a single-ended or differential choice and a clock-divider value. It then pulses a start request. The controller pulls chip select low and generates the serial clock from the system clock. It shifts out a high start bit followed by the assignment word, and then stops driving the data wire so that the converter can use the same wire for its reply.

The converter answers with one settling slot that carries no data. It then sends the byte most significant bit first, followed by the same byte least significant bit first. The two copies share the LSB. The controller discards the settling slot and captures both copies. It compares the bit-reversed second copy with the first. It then raises chip select, pulses done for one cycle, and holds the result and the disagreement flag until the next accepted start. Chip select stays high for a programmable minimum time before the next frame begins.

The sequencer has seven states. IDLE waits for a start. ADDR shifts the address bits. SETTLE skips the settling slot and releases the wire. MSBF takes eight bits. LSBF takes seven bits. TAIL waits for the final low clock phase. GAP holds chip select high. The transitions are as follows:
- IDLE to ADDR on start.
- ADDR to SETTLE on the rising edge of the last address bit.
- SETTLE to MSBF on the next rising edge.
- MSBF to LSBF after the eighth captured bit.
- LSBF to TAIL after the seventh captured bit.
- TAIL to GAP on the following falling edge.
- GAP to IDLE once the gap count expires.

Top module: `sadc_host`

## Requirements
- R1: A start request is accepted only in IDLE, where busy_o is low. A start raised while busy_o is high is ignored and does not begin or disturb a frame.
- R2: After reset, cs_n_o is high and sclk_o is low. cs_n_o falls in the cycle after an accepted start and stays low until the last falling edge of sclk_o in the frame. sclk_o is never high while cs_n_o is high.
- R3: Each phase of sclk_o lasts H system cycles, where H is div_i latched at the accepted start, or 1 when that value is 0. The first phase after chip select falls is low.
- R4: The address bits go out MSB first and change only while sclk_o is low. The first bit is 1 (start). Next comes ~diff_i (1 = single-ended). Next comes chan_i[0] (the odd member, which is the positive input in differential mode). Last come chan_i[CHW-1:1] from the high bit down. One bit is sent per sclk period, and mosi_oe_o is high throughout.
- R5: mosi_oe_o falls together with the falling edge of sclk_o that ends the last address period. While mosi_oe_o is low, mosi_o is 0.
- R6: The value on miso_i at the rising edge that follows the address periods is ignored.
- R7: The next eight rising edges sample miso_i as result bits 7 down to 0, and result_o carries that byte.
- R8: The next seven rising edges sample result bits 1 to 7. mismatch_o is 1 exactly when the byte formed from these seven bits and the shared bit 0 differs from result_o.
- R9: done_o is high for one cycle, in the same cycle that cs_n_o rises. result_o and mismatch_o change only in that cycle.
- R10: After a frame, cs_n_o stays high for at least CS_GAP system cycles. A start held during that time is taken only once the gap has passed.
- R11: A frame contains exactly CHW+2+16 rising edges of sclk_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken in IDLE only |
| chan_i | input | CHW | Channel number; the low bit selects the odd member / polarity |
| diff_i | input | 1 | 1 = differential pair, 0 = single-ended |
| div_i | input | DIV_W | Serial clock phase length in system cycles (0 treated as 1) |
| busy_o | output | 1 | High from the accepted start until the gap ends |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DATA_W | Captured MSB-first byte |
| mismatch_o | output | 1 | The two copies of the byte disagree |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Address data toward the converter |
| mosi_oe_o | output | 1 | Drive enable for the shared data wire |
| miso_i | input | 1 | Data from the converter |

## Verification
The completion pulse and a new start request can land in the same cycle. The bench provokes this by holding start_i high across several frames, so the request is already present when done_o fires and throughout the gap. A behavioural model, which counts cycles from each acceptance, predicts every output on every clock. The model requires that the held request is taken only in the first IDLE cycle after the gap, that done_o fires once, and that the previous result stays unchanged until the next done. A converter model drives junk into the settling slot and can corrupt one bit of the second copy, which exercises the discard and the disagreement paths.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETTLE,
        ST_MSBF,
        ST_LSBF,
        ST_TAIL,
        ST_GAP
    } sadc_state_e;

    // States during which chip select is low and the serial clock runs.
    function automatic logic in_frame(sadc_state_e s);
        return (s == ST_ADDR) || (s == ST_SETTLE) || (s == ST_MSBF) ||
               (s == ST_LSBF) || (s == ST_TAIL);
    endfunction

endpackage

// File: rtl/sadc_clkgen.sv
module sadc_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic             wrap;

    assign wrap   = run_i && (cnt_q == half_i - DIV_W'(1));
    assign rise_o = wrap && !sclk_q;
    assign fall_o = wrap && sclk_q;
    assign sclk_o = sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (!run_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            sclk_q <= !sclk_q;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/sadc_addr_tx.sv
module sadc_addr_tx #(
    parameter int ADDR_N = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_N-1:0] word_i,
    input  logic              shift_i,
    input  logic              release_i,
    output logic              mosi_o,
    output logic              oe_o
);
    logic [ADDR_N-1:0] sr_q;
    logic              oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
            oe_q <= 1'b0;
        end else if (load_i) begin
            sr_q <= word_i;
            oe_q <= 1'b1;
        end else begin
            if (shift_i)   sr_q <= {sr_q[ADDR_N-2:0], 1'b0};
            if (release_i) oe_q <= 1'b0;
        end
    end

    assign mosi_o = oe_q && sr_q[ADDR_N-1];
    assign oe_o   = oe_q;
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              msb_en_i,
    input  logic              lsb_en_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] msb_o,
    output logic              agree_o
);
    logic [DATA_W-1:0] msb_q;
    logic [DATA_W-2:0] lsb_hi_q;
    logic [DATA_W-1:0] lsb_byte;
    logic [DATA_W-1:0] diff_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msb_q    <= '0;
            lsb_hi_q <= '0;
        end else if (clr_i) begin
            msb_q    <= '0;
            lsb_hi_q <= '0;
        end else begin
            if (msb_en_i) msb_q    <= {msb_q[DATA_W-2:0], bit_i};
            if (lsb_en_i) lsb_hi_q <= {bit_i, lsb_hi_q[DATA_W-2:1]};
        end
    end

    // The second copy reuses bit 0 of the first one.
    assign lsb_byte = {lsb_hi_q, msb_q[0]};

    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_cmp
            assign diff_bits[g] = lsb_byte[g] ^ msb_q[g];
        end
    endgenerate

    assign agree_o = (diff_bits == '0);
    assign msb_o   = msb_q;
endmodule

// File: rtl/sadc_host.sv
module sadc_host
    import sadc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int CS_GAP = 4,
    localparam int CHW   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CHW-1:0]    chan_i,
    input  logic              diff_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o,
    output logic              mismatch_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              mosi_oe_o,
    input  logic              miso_i
);
    localparam int ADDR_N = CHW + 2;
    localparam int CNT_W  = $clog2(ADDR_N + DATA_W);
    localparam int GAP_W  = $clog2(CS_GAP + 1);

    sadc_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [GAP_W-1:0]  gap_q;
    logic [DIV_W-1:0]  half_q;
    logic              cs_n_q, done_q, mism_q;
    logic [DATA_W-1:0] result_q;
    logic              rise, fall, accept;
    logic [ADDR_N-1:0] word;
    logic [DATA_W-1:0] msb_byte;
    logic              agree;

    assign accept = (state_q == ST_IDLE) && start_i;

    // Assignment word: start, single-ended flag, odd select, then pair select.
    generate
        if (CHW > 1) begin : g_sel
            assign word = {1'b1, !diff_i, chan_i[0], chan_i[CHW-1:1]};
        end else begin : g_nosel
            assign word = {1'b1, !diff_i, chan_i[0]};
        end
    endgenerate

    sadc_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (in_frame(state_q)),
        .half_i (half_q),
        .sclk_o (sclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    sadc_addr_tx #(.ADDR_N(ADDR_N)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .word_i    (word),
        .shift_i   ((state_q == ST_ADDR) && fall),
        .release_i ((state_q == ST_SETTLE) && fall),
        .mosi_o    (mosi_o),
        .oe_o      (mosi_oe_o)
    );

    sadc_capture #(.DATA_W(DATA_W)) cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (accept),
        .msb_en_i ((state_q == ST_MSBF) && rise),
        .lsb_en_i ((state_q == ST_LSBF) && rise),
        .bit_i    (miso_i),
        .msb_o    (msb_byte),
        .agree_o  (agree)
    );

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ADDR;
            ST_ADDR:   if (rise && cnt_q == CNT_W'(ADDR_N - 1)) state_d = ST_SETTLE;
            ST_SETTLE: if (rise) state_d = ST_MSBF;
            ST_MSBF:   if (rise && cnt_q == CNT_W'(DATA_W - 1)) state_d = ST_LSBF;
            ST_LSBF:   if (rise && cnt_q == CNT_W'(DATA_W - 2)) state_d = ST_TAIL;
            ST_TAIL:   if (fall) state_d = ST_GAP;
            ST_GAP:    if (gap_q == GAP_W'(CS_GAP - 1)) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and its counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= '0;
            else if (rise && (state_q == ST_ADDR || state_q == ST_MSBF ||
                              state_q == ST_LSBF))
                cnt_q <= cnt_q + CNT_W'(1);
            gap_q <= (state_q == ST_GAP) ? gap_q + GAP_W'(1) : '0;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q   <= 1'b1;
            done_q   <= 1'b0;
            result_q <= '0;
            mism_q   <= 1'b0;
            half_q   <= DIV_W'(1);
        end else begin
            cs_n_q <= !in_frame(state_d);
            done_q <= (state_q == ST_TAIL) && fall;
            if ((state_q == ST_TAIL) && fall) begin
                result_q <= msb_byte;
                mism_q   <= !agree;
            end
            if (accept)
                half_q <= (div_i == '0) ? DIV_W'(1) : div_i;
        end
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
    assign result_o   = result_q;
    assign mismatch_o = mism_q;
    assign cs_n_o     = cs_n_q;
endmodule

// File: rtl/sadc_host_chk.sv
module sadc_host_chk #(
    parameter int DATA_W = 8,
    parameter int CS_GAP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] result_o,
    input logic              mismatch_o,
    input logic              cs_n_o,
    input logic              sclk_o,
    input logic              mosi_o,
    input logic              mosi_oe_o
);
    localparam int HW = $clog2(CS_GAP + 1) + 1;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= HW'(CS_GAP);
        else if (!cs_n_o)
            hi_cnt <= '0;
        else if (hi_cnt < HW'(CS_GAP))
            hi_cnt <= hi_cnt + HW'(1);
    end

    p_accept_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> ($past(start_i) && !$past(busy_o)));

    p_sclk_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);

    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    p_release_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mosi_oe_o) |-> $fell(sclk_o));

    p_oe_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mosi_oe_o |-> !cs_n_o);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_with_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $rose(cs_n_o));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(mismatch_o)));

    p_cs_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (hi_cnt >= HW'(CS_GAP)));
endmodule

bind sadc_host sadc_host_chk #(.DATA_W(DATA_W), .CS_GAP(CS_GAP)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .mismatch_o (mismatch_o),
    .cs_n_o     (cs_n_o),
    .sclk_o     (sclk_o),
    .mosi_o     (mosi_o),
    .mosi_oe_o  (mosi_oe_o)
);

// File: tb/sadc_host_tb_top.sv
module sadc_host_tb_top;
    localparam int NUM_CH = 8;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 8;
    localparam int CS_GAP = 4;
    localparam int CHW    = 3;
    localparam int ADDR_N = CHW + 2;
    localparam int NPER   = ADDR_N + 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [CHW-1:0]    chan_i = '0;
    logic              diff_i = 1'b0;
    logic [DIV_W-1:0]  div_i = '0;
    logic              busy_o, done_o, mismatch_o, cs_n_o, sclk_o, mosi_o, mosi_oe_o;
    logic [DATA_W-1:0] result_o;
    logic              miso_i = 1'b0;

    always #2 clk = !clk;

    sadc_host #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .DIV_W(DIV_W), .CS_GAP(CS_GAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i), .diff_i(diff_i),
        .div_i(div_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .mismatch_o(mismatch_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o),
        .mosi_oe_o(mosi_oe_o), .miso_i(miso_i)
    );

    int errs = 0;
    int checks = 0;
    bit finished = 1'b0;

    task automatic chk(int act, int exp, string req, string what);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: cycles elapsed since the accepted start.
    bit                m_act = 1'b0;
    int                m_k, m_h, m_T;
    logic [ADDR_N-1:0] m_word;
    logic [7:0]        m_data;
    bit                m_inj;
    logic [7:0]        dev_data = '0;
    bit                dev_inj = 1'b0;
    bit                have_res = 1'b0;
    logic [7:0]        exp_res;
    bit                exp_mis;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 1'b0;
        end else if (!m_act && start_i) begin
            m_act  = 1'b1;
            m_k    = 0;
            m_h    = (div_i == 0) ? 1 : int'(div_i);
            m_T    = 2 * m_h * NPER + CS_GAP;
            m_word = {1'b1, !diff_i, chan_i[0], chan_i[2:1]};
            m_data = dev_data;
            m_inj  = dev_inj;
        end else if (m_act) begin
            m_k++;
            if (m_k == m_T) m_act = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_cs, e_sclk, e_oe, e_mosi, e_done;
            if (m_act) begin
                e_cs   = (m_k >= 2 * m_h * NPER);
                e_sclk = !e_cs && (((m_k / m_h) % 2) == 1);
                e_oe   = (m_k < 2 * m_h * ADDR_N);
                e_mosi = e_oe ? m_word[ADDR_N - 1 - m_k / (2 * m_h)] : 1'b0;
                e_done = (m_k == 2 * m_h * NPER);
            end else begin
                e_cs = 1'b1; e_sclk = 1'b0; e_oe = 1'b0; e_mosi = 1'b0; e_done = 1'b0;
            end
            chk(int'(busy_o), int'(m_act), "R1", "busy_o");
            chk(int'(cs_n_o), int'(e_cs), "R2 R10", "cs_n_o");
            chk(int'(sclk_o), int'(e_sclk), "R3", "sclk_o");
            chk(int'(mosi_o), int'(e_mosi), "R4", "mosi_o");
            chk(int'(mosi_oe_o), int'(e_oe), "R5", "mosi_oe_o");
            chk(int'(done_o), int'(e_done), "R9", "done_o");
            if (e_done) begin
                have_res = 1'b1;
                exp_res  = m_data;
                exp_mis  = m_inj;
            end
            if (have_res) begin
                // R6: settle-slot junk must not reach the result.
                chk(int'(result_o), int'(exp_res), "R7", "result_o");
                chk(int'(mismatch_o), int'(exp_mis), "R8", "mismatch_o");
            end
        end
    end

    // Converter model on the serial pins.
    int                dev_q = 0;
    logic [ADDR_N-1:0] dev_cap = '0;

    function automatic logic dev_bit(int q);
        logic b;
        if (q == ADDR_N) return 1'b1;  // R6: junk in the settling slot
        if (q >= ADDR_N + 1 && q <= ADDR_N + 8) return m_data[7 - (q - ADDR_N - 1)];
        if (q >= ADDR_N + 9 && q <= ADDR_N + 15) begin
            b = m_data[q - ADDR_N - 8];
            if (m_inj && q == ADDR_N + 12) b = !b;
            return b;
        end
        return 1'b0;
    endfunction

    always @(posedge sclk_o) begin
        if (dev_q < ADDR_N) dev_cap = {dev_cap[ADDR_N-2:0], mosi_o};
        dev_q++;
    end

    always @(negedge sclk_o) miso_i = dev_bit(dev_q);

    always @(posedge cs_n_o) begin
        if (dev_q > 0 && !finished) begin
            chk(int'(dev_cap), int'(m_word), "R4", "address word");
            chk(dev_q, NPER, "R11", "rising edges in frame");
        end
        dev_q  = 0;
        miso_i = 1'b0;
    end

    task automatic xfer(int dv, int ch, bit df, logic [7:0] data, bit inj, bit hold);
        @(negedge clk);
        div_i    = DIV_W'(dv);
        chan_i   = CHW'(ch);
        diff_i   = df;
        dev_data = data;
        dev_inj  = inj;
        start_i  = 1'b1;
        @(negedge clk);
        if (!hold) begin
            start_i = 1'b0;
            repeat (7) @(negedge clk);
            start_i = 1'b1;            // R1: request while busy
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(int'(cs_n_o), 1, "R2", "reset cs_n_o");
        chk(int'(sclk_o), 0, "R2", "reset sclk_o");
        chk(int'(mosi_oe_o), 0, "R5", "reset mosi_oe_o");
        chk(int'(done_o), 0, "R9", "reset done_o");
        chk(int'(busy_o), 0, "R1", "reset busy_o");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        xfer(1, 0, 1'b0, 8'hA5, 1'b0, 1'b0);
        xfer(2, 5, 1'b0, 8'h3C, 1'b0, 1'b0);
        xfer(3, 2, 1'b1, 8'hFF, 1'b0, 1'b1);   // start held through done (R10)
        xfer(0, 7, 1'b1, 8'h00, 1'b0, 1'b1);   // divider 0 acts as 1 (R3)
        xfer(1, 3, 1'b0, 8'h81, 1'b1, 1'b1);   // corrupted second copy (R8)
        xfer(4, 6, 1'b0, 8'h5A, 1'b1, 1'b0);
        xfer(2, 1, 1'b1, 8'h7E, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule